// File: doc/BRIEF.md
# Task-Selected Page Translation Unit

This block sits between a small CPU with a 16-bit logical address and a memory system with a 20-bit physical space. The upper four logical bits pick one of sixteen 4 KB pages. A translation table, indexed by a context number and that page number, supplies an 8-bit physical frame and two protection flags. The twelve offset bits pass straight through. Translation is combinational, so the physical address is valid in the same cycle as the logical one.

Ordinary accesses take their context from a task latch. Accesses that the CPU tags as made through its return-stack pointer take their context from a separate stack-context register. They also drive one extra physical address bit high. Ordinary accesses always drive that bit low, so no ordinary load or store can reach the return-stack region.

A refused access (a write to a write-protected page, or a read of a read-protected page) pulses a fault output in that cycle and suppresses the memory enable. It also records the logical address, direction and stack tag of the refused access. Table entries, the task latch and the stack-context register are loaded through a configuration port that acts only while the privileged qualifier is high.

Top module: `tpm_unit`

## Requirements
- R1: Physical address bits [11:0] always equal logical address bits [11:0].
- R2: For an access with cpu_rstk=0, phys_addr[19:12] is the frame of the entry at context = task latch, page = cpu_addr[15:12], and phys_addr[20] is 0.
- R3: For an access with cpu_rstk=1, the entry is taken from context = stack-context register (the task latch is not used), and phys_addr[20] is 1.
- R4: A valid write (cpu_wr=1) to an entry whose write-protect flag (data bit 8) is set raises fault in the same cycle with mem_en=0 and mem_we=0.
- R5: A valid read (cpu_wr=0) of an entry whose read-protect flag (data bit 9) is set raises fault in the same cycle with mem_en=0 and mem_we=0.
- R6: Any other valid access gives fault=0, mem_en=1 and mem_we=cpu_wr, so a write to a read-protected-only page and a read of a write-protected-only page both proceed. With cpu_valid=0, fault, mem_en and mem_we are all 0.
- R7: From the clock edge after a faulting access, flt_addr, flt_wr and flt_rstk hold that access's logical address, direction and stack tag, and they keep those values until the next fault.
- R8: A configuration write with cfg_tgt=0 stores cfg_data into the entry at cfg_idx ({context[3:0], page[3:0]}), laid out as bit 9 read-protect, bit 8 write-protect, bits 7:0 frame. It is visible from the next cycle. Any configuration write with cfg_priv=0 changes nothing.
- R9: A privileged write with cfg_tgt=1 loads the task latch from cfg_data[3:0]. A privileged write with cfg_tgt=2 loads the stack-context register from cfg_data[3:0]. A write with cfg_tgt=3 has no effect.
- R10: After reset the task latch and stack context are 0, every entry has frame 0 and no protection, and the fault record is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | An access is presented this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_rstk | input | 1 | Access is made through the return-stack pointer |
| cpu_addr | input | 16 | Logical address |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Privileged qualifier for configuration writes |
| cfg_tgt | input | 2 | Target: 0 entry, 1 task latch, 2 stack context, 3 none |
| cfg_idx | input | 8 | Entry index {context, page} |
| cfg_data | input | 10 | Entry data {rp, wp, frame} or context number in [3:0] |
| phys_addr | output | 21 | {stack region bit, frame, offset} |
| mem_en | output | 1 | Access allowed to proceed |
| mem_we | output | 1 | Allowed write |
| fault | output | 1 | Protection violation this cycle |
| flt_addr | output | 16 | Logical address of the last faulting access |
| flt_wr | output | 1 | Direction of the last faulting access |
| flt_rstk | output | 1 | Stack tag of the last faulting access |

## Verification
The assertions assume that every input is settled at each rising edge and that cfg_tgt, cpu_wr and cpu_rstk carry known values whenever their strobes are high. The bench meets this by changing inputs only on falling edges. It keeps cpu_valid low in configuration cycles, so each access sees a table that has already been written. Protection-flag and direction combinations are swept across a full context of entries, so that read and write refusal are each exercised with both flag settings.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef enum logic [1:0] {
    TGT_ENTRY = 2'd0,
    TGT_TASK  = 2'd1,
    TGT_STACK = 2'd2,
    TGT_NONE  = 2'd3
  } cfg_tgt_e;

  // Refusal rule: writes check write-protect, reads check read-protect.
  function automatic logic tpm_refused(input logic is_wr, input logic rp, input logic wp);
    return is_wr ? wp : rp;
  endfunction

endpackage

// File: rtl/tpm_xlate_ram.sv
module tpm_xlate_ram #(
  parameter int AW    = 8,
  parameter int ENT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tpm_ctx_regs.sv
module tpm_ctx_regs
  import tpm_pkg::*;
#(
  parameter int TASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_priv,
  input  logic [1:0]        cfg_tgt,
  input  logic [TASK_W-1:0] cfg_val,
  output logic [TASK_W-1:0] task_q,
  output logic [TASK_W-1:0] stk_q
);
  logic load_task, load_stk;

  assign load_task = cfg_wr && cfg_priv && (cfg_tgt == TGT_TASK);
  assign load_stk  = cfg_wr && cfg_priv && (cfg_tgt == TGT_STACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      task_q <= '0;
      stk_q  <= '0;
    end else begin
      if (load_task) task_q <= cfg_val;
      if (load_stk)  stk_q  <= cfg_val;
    end
  end

  AST_UNPRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_priv) |=> ($stable(task_q) && $stable(stk_q))); // R8

  AST_NONE_TGT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tgt == TGT_NONE) |=> ($stable(task_q) && $stable(stk_q))); // R9

endmodule

// File: rtl/tpm_fault_cap.sv
module tpm_fault_cap #(
  parameter int LA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            viol,
  input  logic [LA_W-1:0] addr,
  input  logic            is_wr,
  input  logic            is_rstk,
  output logic [LA_W-1:0] flt_addr,
  output logic            flt_wr,
  output logic            flt_rstk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_addr <= '0;
      flt_wr   <= 1'b0;
      flt_rstk <= 1'b0;
    end else if (viol) begin
      flt_addr <= addr;
      flt_wr   <= is_wr;
      flt_rstk <= is_rstk;
    end
  end

  AST_FAULT_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (flt_addr == $past(addr) && flt_wr == $past(is_wr) && flt_rstk == $past(is_rstk))); // R7

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |=> ($stable(flt_addr) && $stable(flt_wr) && $stable(flt_rstk))); // R7

endmodule

// File: rtl/tpm_unit.sv
module tpm_unit
  import tpm_pkg::*;
#(
  parameter int LA_W    = 16,
  parameter int OFF_W   = 12,
  parameter int TASK_W  = 4,
  parameter int FRAME_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_valid,
  input  logic                           cpu_wr,
  input  logic                           cpu_rstk,
  input  logic [LA_W-1:0]                cpu_addr,
  input  logic                           cfg_wr,
  input  logic                           cfg_priv,
  input  logic [1:0]                     cfg_tgt,
  input  logic [TASK_W+LA_W-OFF_W-1:0]   cfg_idx,
  input  logic [FRAME_W+1:0]             cfg_data,
  output logic [FRAME_W+OFF_W:0]         phys_addr,
  output logic                           mem_en,
  output logic                           mem_we,
  output logic                           fault,
  output logic [LA_W-1:0]                flt_addr,
  output logic                           flt_wr,
  output logic                           flt_rstk
);
  localparam int IDX_W  = LA_W - OFF_W;
  localparam int RAM_AW = TASK_W + IDX_W;
  localparam int ENT_W  = FRAME_W + 2;
  localparam int PA_W   = FRAME_W + OFF_W + 1;
  localparam int RP_BIT = FRAME_W + 1;
  localparam int WP_BIT = FRAME_W;

  function automatic logic [PA_W-1:0] compose_pa(input logic region,
                                                 input logic [FRAME_W-1:0] frame,
                                                 input logic [OFF_W-1:0] off);
    return {region, frame, off};
  endfunction

  logic [TASK_W-1:0] task_q, stk_q, ctx_sel;
  logic [RAM_AW-1:0] lkup_idx;
  logic [ENT_W-1:0]  lkup_ent;
  logic              ent_rp, ent_wp, viol, tbl_we;
  logic [FRAME_W-1:0] ent_frame;

  assign tbl_we = cfg_wr && cfg_priv && (cfg_tgt == TGT_ENTRY);

  tpm_ctx_regs #(.TASK_W(TASK_W)) u_ctx (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv),
    .cfg_tgt(cfg_tgt), .cfg_val(cfg_data[TASK_W-1:0]),
    .task_q(task_q), .stk_q(stk_q)
  );

  assign ctx_sel  = cpu_rstk ? stk_q : task_q;
  assign lkup_idx = {ctx_sel, cpu_addr[LA_W-1:OFF_W]};

  tpm_xlate_ram #(.AW(RAM_AW), .ENT_W(ENT_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(cfg_idx), .wdata(cfg_data),
    .raddr(lkup_idx), .rdata(lkup_ent)
  );

  assign ent_frame = lkup_ent[FRAME_W-1:0];
  assign ent_rp    = lkup_ent[RP_BIT];
  assign ent_wp    = lkup_ent[WP_BIT];
  assign viol      = cpu_valid && tpm_refused(cpu_wr, ent_rp, ent_wp);

  assign phys_addr = compose_pa(cpu_rstk, ent_frame, cpu_addr[OFF_W-1:0]);
  assign fault     = viol;
  assign mem_en    = cpu_valid && !viol;
  assign mem_we    = mem_en && cpu_wr;

  tpm_fault_cap #(.LA_W(LA_W)) u_flt (
    .clk(clk), .rst_n(rst_n), .viol(viol), .addr(cpu_addr),
    .is_wr(cpu_wr), .is_rstk(cpu_rstk),
    .flt_addr(flt_addr), .flt_wr(flt_wr), .flt_rstk(flt_rstk)
  );

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]); // R1

  AST_ORDINARY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_rstk) |-> !phys_addr[PA_W-1]); // R2

  AST_STACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_rstk) |-> phys_addr[PA_W-1]); // R3

  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_en && !mem_we)); // R4

  AST_WE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cpu_wr && cpu_valid)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_valid |-> (!fault && !mem_en)); // R6

endmodule

// File: tb/tpm_unit_bench.sv
module tpm_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0, cpu_wr = 1'b0, cpu_rstk = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cfg_wr = 1'b0, cfg_priv = 1'b0;
  logic [1:0]  cfg_tgt = '0;
  logic [7:0]  cfg_idx = '0;
  logic [9:0]  cfg_data = '0;
  logic [20:0] phys_addr;
  logic        mem_en, mem_we, fault;
  logic [15:0] flt_addr;
  logic        flt_wr, flt_rstk;

  always #5 clk = ~clk;

  tpm_unit u_tpm_unit (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_wr(cpu_wr),
    .cpu_rstk(cpu_rstk), .cpu_addr(cpu_addr), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv),
    .cfg_tgt(cfg_tgt), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .phys_addr(phys_addr), .mem_en(mem_en), .mem_we(mem_we), .fault(fault),
    .flt_addr(flt_addr), .flt_wr(flt_wr), .flt_rstk(flt_rstk)
  );

  typedef struct packed {
    logic        chk_pa;
    logic [20:0] pa;
    logic        flt, en, we;
    logic [15:0] fa;
    logic        fw, fr;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    checks = 0;
  int    errors = 0;

  // Bench-side model of the mapping state
  logic [9:0]  mdl [256];
  logic [3:0]  m_task = '0, m_stk = '0;
  logic [15:0] m_fa = '0;
  logic        m_fw = 1'b0, m_fr = 1'b0;

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the item pushed at this falling edge and compares mid-phase
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (expq.size() > 0) begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (e.chk_pa) cmp(t, "phys_addr", {11'd0, phys_addr}, {11'd0, e.pa});
        cmp(t, "fault", {31'd0, fault}, {31'd0, e.flt});
        cmp(t, "mem_en", {31'd0, mem_en}, {31'd0, e.en});
        cmp(t, "mem_we", {31'd0, mem_we}, {31'd0, e.we});
        cmp(t, "flt_record", {14'd0, flt_addr, flt_wr, flt_rstk}, {14'd0, e.fa, e.fw, e.fr});
      end
    end
  end

  task automatic cfg(input logic priv, input logic [1:0] tgt, input logic [7:0] idx, input logic [9:0] data);
    @(negedge clk);
    cpu_valid = 1'b0;
    cfg_wr = 1'b1; cfg_priv = priv; cfg_tgt = tgt; cfg_idx = idx; cfg_data = data;
    if (priv) begin
      if (tgt == 2'd0) mdl[idx] = data;
      else if (tgt == 2'd1) m_task = data[3:0];
      else if (tgt == 2'd2) m_stk = data[3:0];
    end
  endtask

  task automatic acc(input logic wr, input logic rstk, input logic [15:0] a, input string tag);
    logic [3:0] ctx;
    logic [9:0] ent;
    logic       bad;
    exp_t       e;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_priv = 1'b0;
    cpu_valid = 1'b1; cpu_wr = wr; cpu_rstk = rstk; cpu_addr = a;
    ctx = rstk ? m_stk : m_task;
    ent = mdl[{ctx, a[15:12]}];
    bad = wr ? ent[8] : ent[9];
    e.chk_pa = 1'b1;
    e.pa  = {rstk, ent[7:0], a[11:0]};
    e.flt = bad;
    e.en  = !bad;
    e.we  = !bad && wr;
    e.fa = m_fa; e.fw = m_fw; e.fr = m_fr;
    expq.push_back(e);
    tagq.push_back(tag);
    if (bad) begin m_fa = a; m_fw = wr; m_fr = rstk; end
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_priv = 1'b0; cpu_valid = 1'b0;
    cpu_wr = 1'b1; cpu_addr = 16'h2000;
    e = '0;
    e.fa = m_fa; e.fw = m_fw; e.fr = m_fr;
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R10: reset state, frame 0, no protection, empty record
    acc(1'b0, 1'b0, 16'h1234, "R10 reset read");
    acc(1'b1, 1'b0, 16'hF00D, "R10 reset write");

    // R2 / R1 / R6: plain mapping
    cfg(1'b1, 2'd0, 8'h01, 10'h05A);
    acc(1'b0, 1'b0, 16'h1ABC, "R2 R1 read map");
    acc(1'b1, 1'b0, 16'h1FFF, "R6 write map");

    // R4 write-protect
    cfg(1'b1, 2'd0, 8'h02, 10'h133);
    acc(1'b1, 1'b0, 16'h2010, "R4 write to wp page");
    acc(1'b0, 1'b0, 16'h2010, "R6 R7 read of wp page and record");

    // R5 read-protect
    cfg(1'b1, 2'd0, 8'h03, 10'h244);
    acc(1'b0, 1'b0, 16'h3456, "R5 read of rp page");
    acc(1'b1, 1'b0, 16'h3456, "R6 R7 write of rp page and record");

    // R9 task latch
    cfg(1'b1, 2'd1, 8'h00, 10'h005);
    cfg(1'b1, 2'd0, 8'h51, 10'h0C1);
    acc(1'b0, 1'b0, 16'h1FFF, "R9 task latch selects context");

    // R9 / R3 stack context
    cfg(1'b1, 2'd2, 8'h00, 10'h009);
    cfg(1'b1, 2'd0, 8'h9F, 10'h077);
    acc(1'b0, 1'b1, 16'hF0F0, "R3 stack access");
    acc(1'b0, 1'b0, 16'hF0F0, "R3 ordinary same address");

    // R8 unprivileged writes ignored
    cfg(1'b0, 2'd1, 8'h00, 10'h002);
    acc(1'b0, 1'b0, 16'h1000, "R8 unpriv task write ignored");
    cfg(1'b0, 2'd0, 8'h51, 10'h3EE);
    acc(1'b1, 1'b0, 16'h1000, "R8 unpriv entry write ignored");
    cfg(1'b0, 2'd2, 8'h00, 10'h005);
    acc(1'b0, 1'b1, 16'hF123, "R8 unpriv stack write ignored");

    // R9 target 3 does nothing
    cfg(1'b1, 2'd3, 8'h51, 10'h003);
    acc(1'b0, 1'b0, 16'h1777, "R9 none target task");
    acc(1'b0, 1'b1, 16'hF777, "R9 none target stack");

    // R7 stack-tagged fault
    cfg(1'b1, 2'd0, 8'h9E, 10'h1AA);
    acc(1'b1, 1'b1, 16'hE00E, "R4 R7 stack write fault");
    acc(1'b0, 1'b1, 16'hE00E, "R7 stack record");

    // R6 idle
    idle("R6 idle quiet");

    // Sweep one context with mixed flags
    for (int i = 0; i < 16; i++) begin
      logic [9:0] d;
      d = {i[1:0], 8'(i * 17 + 3)};
      cfg(1'b1, 2'd0, {4'h5, 4'(i)}, d);
    end
    for (int i = 0; i < 16; i++) begin
      acc(1'b0, 1'b0, {4'(i), 12'(i * 291)}, "R2 R5 sweep read");
      acc(1'b1, 1'b0, {4'(i), 12'(4095 - i)}, "R4 R6 sweep write");
    end
    idle("R7 final record");

    @(negedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule